// File: doc/BRIEF.md
# Sixteen-bit timer/counter with capture, auto-reload and baud tick generation

This block is a 16-bit up-counter under the control of a byte-wide register port. As a timer it advances on a prescaled system clock, one step every 12 or every 4 clocks, and the choice comes from an external select input. As an event counter it advances on each falling transition of an external count pin. A second external pin, the trigger, can either copy the running count into a shared capture/reload register or force the counter to load from that register. A software-enable bit in the control byte gates this pin.

The control byte also has two serial-clock select bits. When either is set, the block acts as a baud generator. The count advances every 2 clocks and reloads from the shared register on each wrap. Every wrap produces a one-cycle pulse on the receive and/or transmit baud output. In this mode the overflow flag stays clear and the trigger pin does nothing. Two sticky flags, overflow and external, combine into a registered interrupt request. Software can set either flag or clear it through the control byte.

Top module: `timer16_capreload`

## Requirements
- R1: After a synchronous reset, every register reads 0 and irq, rx_baud_tick and tx_baud_tick are 0. The register map is: address 0 holds the control byte, addresses 1/2 hold the counter low/high byte, addresses 3/4 hold the capture/reload low/high byte. Reads are registered, one cycle after the address is presented. The control bits are: bit0 run, bit1 count-pin mode, bit2 capture mode, bit3 trigger enable, bit4 receive baud select, bit5 transmit baud select, bit6 external flag, bit7 overflow flag.
- R2: In timer mode with run=1 and both baud selects 0, the counter advances once every 12 clocks when fast_tick_sel=0 and once every 4 clocks when fast_tick_sel=1. After run is written to 1 and then held for M clock edges, the counter has advanced floor(M/divisor) times.
- R3: With run=0, the counter does not change, whether the clock is running or the count pin toggles.
- R4: With count-pin mode=1 and run=1, the counter advances by exactly one for each falling edge on cnt_pin. Each pin passes through a two-stage synchronizer.
- R5: With capture mode=1 and trigger enable=1, a falling edge on trig_pin copies the counter into the capture/reload register, sets the external flag and leaves the counter running. With trigger enable=0, the edge has no effect.
- R6: With capture mode=0 and trigger enable=1, a falling edge on trig_pin loads the counter from the capture/reload register and sets the external flag.
- R7: On a wrap from FFFFh outside baud mode, the overflow flag is set. The counter loads the reload register if capture mode=0 and goes to 0 if capture mode=1.
- R8: With either baud select at 1, the counter advances every 2 clocks regardless of fast_tick_sel and reloads on every wrap. The overflow flag stays 0. Each wrap gives a one-cycle pulse on rx_baud_tick if the receive select is 1 and on tx_baud_tick if the transmit select is 1.
- R9: In baud mode, trig_pin edges neither capture nor reload and do not set the external flag.
- R10: irq is 1 one cycle after either flag is 1. Flags stay set until software writes 0 to them, and writing 1 to a flag sets it. A hardware set in the same cycle as a software write wins.
- R11: When a trigger capture and a counter wrap fall in the same cycle, the capture register receives FFFFh, the counter goes to 0 and both flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| fast_tick_sel | input | 1 | Timer prescale select: 1 gives 4 clocks per step, 0 gives 12 |
| cnt_pin | input | 1 | External count input, falling edges counted |
| trig_pin | input | 1 | External capture/reload trigger, falling edges active |
| irq | output | 1 | Interrupt request, OR of the two flags |
| rx_baud_tick | output | 1 | One-cycle receive baud pulse |
| tx_baud_tick | output | 1 | One-cycle transmit baud pulse |

## Verification
A trigger capture can land in the same cycle as a counter wrap. The design has to take the pre-wrap value into the capture register while it also wraps the counter and sets both flags. The bench provokes this in count-pin mode. It presets the counter to FFFFh and drops cnt_pin and trig_pin together, so both edges leave the identical synchronizers on the same clock. It then judges the result by reading back the capture register, the counter and the control byte. Random timer runs with random lengths and prescale choices cover the rate logic against a bench formula. Directed cases cover the reload, wrap and baud paths.

// File: rtl/t16_pkg.sv
package t16_pkg;
  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic tx_sel;
    logic rx_sel;
    logic trig_en;
    logic cap_mode;
    logic pin_mode;
    logic run;
  } t16_ctrl_t;

  localparam int CTRL_ADDR = 0;
  localparam int CTRL_W    = 8;
endpackage

// File: rtl/t16_edge_sync.sv
module t16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= '1;
      prev_q <= 1'b1;
    end else begin
      stg_q  <= {stg_q[STAGES-2:0], pin};
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign fall = prev_q && !stg_q[STAGES-1];
endmodule

// File: rtl/t16_prescale.sv
module t16_prescale #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int DIV_BAUD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic baud,
  input  logic fast_sel,
  output logic tick
);
  localparam int DMAX = (DIV_SLOW > DIV_FAST) ?
                        ((DIV_SLOW > DIV_BAUD) ? DIV_SLOW : DIV_BAUD) :
                        ((DIV_FAST > DIV_BAUD) ? DIV_FAST : DIV_BAUD);
  localparam int PW = $clog2(DMAX + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  always_comb begin
    if (baud)          limit = PW'(DIV_BAUD - 1);
    else if (fast_sel) limit = PW'(DIV_FAST - 1);
    else               limit = PW'(DIV_SLOW - 1);
  end

  assign tick = en && (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !en)  pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/t16_core.sv
module t16_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              trig_reload,
  input  logic              trig_capture,
  input  logic              ovf_reload,
  input  logic [CNT_W/DATA_W-1:0] cnt_we,
  input  logic [CNT_W/DATA_W-1:0] rld_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  rld_q,
  output logic              ovf
);
  localparam int NB = CNT_W / DATA_W;

  assign ovf = inc && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (|cnt_we) begin
        for (int i = 0; i < NB; i++)
          if (cnt_we[i]) cnt_q[i*DATA_W +: DATA_W] <= wdata;
      end else if (trig_reload || (ovf && ovf_reload)) begin
        cnt_q <= rld_q;
      end else if (ovf) begin
        cnt_q <= '0;
      end else if (inc) begin
        cnt_q <= cnt_q + 1'b1;
      end

      if (trig_capture) begin
        rld_q <= cnt_q;
      end else begin
        for (int i = 0; i < NB; i++)
          if (rld_we[i]) rld_q[i*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/timer16_capreload.sv
module timer16_capreload #(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int DIV_BAUD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fast_tick_sel,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  output logic              irq,
  output logic              rx_baud_tick,
  output logic              tx_baud_tick
);
  import t16_pkg::*;

  localparam int NB = CNT_W / DATA_W;

  t16_ctrl_t         ctrl_q, ctrl_nxt;
  logic              cnt_fall, trig_fall, pre_tick;
  logic              baud, inc, trig_evt, ovf;
  logic [NB-1:0]     cnt_we, rld_we;
  logic [CNT_W-1:0]  cnt_q, rld_q;
  logic [DATA_W-1:0] rd_nxt;
  logic              ctrl_wr;

  t16_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall));

  t16_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall));

  assign baud     = ctrl_q.rx_sel || ctrl_q.tx_sel;
  assign trig_evt = trig_fall && ctrl_q.trig_en && !baud;
  assign inc      = ctrl_q.run && (ctrl_q.pin_mode ? cnt_fall : pre_tick);
  assign ctrl_wr  = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));

  t16_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .DIV_BAUD(DIV_BAUD)) u_pre (
    .clk(clk), .rst(rst),
    .en(ctrl_q.run && !ctrl_q.pin_mode),
    .baud(baud), .fast_sel(fast_tick_sel), .tick(pre_tick));

  generate
    for (genvar g = 0; g < NB; g++) begin : g_lane_we
      assign cnt_we[g] = reg_we && (reg_addr == ADDR_W'(1 + g));
      assign rld_we[g] = reg_we && (reg_addr == ADDR_W'(1 + NB + g));
    end
  endgenerate

  t16_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .inc(inc),
    .trig_reload(trig_evt && !ctrl_q.cap_mode),
    .trig_capture(trig_evt && ctrl_q.cap_mode),
    .ovf_reload(baud || !ctrl_q.cap_mode),
    .cnt_we(cnt_we), .rld_we(rld_we), .wdata(reg_wdata),
    .cnt_q(cnt_q), .rld_q(rld_q), .ovf(ovf));

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_wr) ctrl_nxt = t16_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    if (ovf && !baud) ctrl_nxt.ovf_flag = 1'b1;
    if (trig_evt)     ctrl_nxt.ext_flag = 1'b1;
  end

  always_comb begin
    rd_nxt = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) rd_nxt = DATA_W'(ctrl_q);
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(1 + i))      rd_nxt = cnt_q[i*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(1 + NB + i)) rd_nxt = rld_q[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q       <= '0;
      reg_rdata    <= '0;
      irq          <= 1'b0;
      rx_baud_tick <= 1'b0;
      tx_baud_tick <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_nxt;
      reg_rdata    <= rd_nxt;
      irq          <= ctrl_q.ovf_flag || ctrl_q.ext_flag;
      rx_baud_tick <= ovf && baud && ctrl_q.rx_sel;
      tx_baud_tick <= ovf && baud && ctrl_q.tx_sel;
    end
  end
endmodule

// File: rtl/t16_checker.sv
module t16_checker
  import t16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input t16_ctrl_t         ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              trig_evt,
  input logic              irq,
  input logic              rx_baud_tick,
  input logic              tx_baud_tick
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));

  a_r8_no_ovf_flag_in_baud: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q.rx_sel || ctrl_q.tx_sel) && !ctrl_q.ovf_flag && !ctrl_wr) |=> !ctrl_q.ovf_flag);

  a_r8_rx_tick_needs_sel: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.rx_sel) |=> !rx_baud_tick);

  a_r8_tx_tick_needs_sel: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.tx_sel) |=> !tx_baud_tick);

  a_r10_irq_rises: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ovf_flag || ctrl_q.ext_flag) |=> irq);

  a_r10_irq_falls: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.ovf_flag && !ctrl_q.ext_flag) |=> !irq);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ovf_flag && !ctrl_wr) |=> ctrl_q.ovf_flag);

  a_r10_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ext_flag && !ctrl_wr) |=> ctrl_q.ext_flag);

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !reg_we && !trig_evt) |=> $stable(cnt_q));
endmodule

bind timer16_capreload t16_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_t16_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .trig_evt(trig_evt), .irq(irq),
  .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick));

// File: tb/timer16_capreload_bench.sv
module timer16_capreload_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       fast_tick_sel = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       irq, rx_baud_tick, tx_baud_tick;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  timer16_capreload u_timer16_capreload (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fast_tick_sel(fast_tick_sel),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq),
    .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick));

  always #10 clk = ~clk;

  function automatic logic [15:0] exp_timer(input logic [15:0] start, input int m, input bit fast);
    return start + 16'(m / (fast ? 4 : 12));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 3'd1, d[15:8]);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic pulse_cnt(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_pin = 1'b0; repeat (3) @(negedge clk);
      cnt_pin = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic fall_trig();
    trig_pin = 1'b0; repeat (5) @(negedge clk);
    trig_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, start;
    int rxc, txc, m;
    bit fast;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, b);   chk("R1 ctrl", b, 8'h00);
    rd16(3'd1, w); chk("R1 counter", w, 16'h0000);
    rd16(3'd3, w); chk("R1 reload", w, 16'h0000);
    chk("R1 outputs", {irq, rx_baud_tick, tx_baud_tick}, 3'b000);

    // R2 random timer runs
    for (int k = 0; k < 8; k++) begin
      fast = 1'($urandom % 2);
      fast_tick_sel = fast;
      m = 20 + int'($urandom % 200);
      start = 16'($urandom % 16'hF000);
      wr16(3'd1, start);
      wr(3'd0, 8'h01);
      repeat (m - 1) @(negedge clk);
      wr(3'd0, 8'h00);
      rd16(3'd1, w);
      chk("R2 timer rate", w, exp_timer(start, m, fast));
    end

    // R3 stopped: clock and pin have no effect
    wr16(3'd1, 16'h3C3C);
    repeat (50) @(negedge clk);
    rd16(3'd1, w); chk("R3 stopped timer", w, 16'h3C3C);
    wr(3'd0, 8'h02);
    pulse_cnt(3);
    rd16(3'd1, w); chk("R3 stopped pin", w, 16'h3C3C);

    // R4 count pin edges
    wr16(3'd1, 16'h0100);
    wr(3'd0, 8'h03);
    repeat (40) @(negedge clk);
    rd16(3'd1, w); chk("R4 no clock counting", w, 16'h0100);
    pulse_cnt(7);
    rd16(3'd1, w); chk("R4 edge count", w, 16'h0107);

    // R5 trigger disabled: no capture
    wr16(3'd3, 16'hAAAA);
    wr(3'd0, 8'h07);
    fall_trig();
    rd16(3'd3, w); chk("R5 disabled capture", w, 16'hAAAA);
    rd(3'd0, b);   chk("R5 disabled flag", b, 8'h07);
    // R5 capture
    wr(3'd0, 8'h0F);
    pulse_cnt(2);
    fall_trig();
    rd16(3'd3, w); chk("R5 captured", w, 16'h0109);
    rd16(3'd1, w); chk("R5 counter kept", w, 16'h0109);
    rd(3'd0, b);   chk("R5 ext flag", b, 8'h4F);
    chk("R10 irq from ext", irq, 1'b1);
    wr(3'd0, 8'h00);
    repeat (2) @(negedge clk);
    chk("R10 irq cleared", irq, 1'b0);

    // R6 trigger reload
    wr16(3'd3, 16'h5A5A);
    wr16(3'd1, 16'h0010);
    wr(3'd0, 8'h0B);
    fall_trig();
    rd16(3'd1, w); chk("R6 reload", w, 16'h5A5A);
    rd(3'd0, b);   chk("R6 ext flag", b, 8'h4B);

    // R7 overflow, reload mode
    wr(3'd0, 8'h00);
    wr16(3'd3, 16'h1234);
    wr16(3'd1, 16'hFFFF);
    wr(3'd0, 8'h03);
    pulse_cnt(1);
    rd16(3'd1, w); chk("R7 reload on wrap", w, 16'h1234);
    rd(3'd0, b);   chk("R7 ovf flag", b, 8'h83);
    chk("R10 irq from ovf", irq, 1'b1);
    // R7 overflow, capture mode
    wr(3'd0, 8'h00);
    wr16(3'd1, 16'hFFFF);
    wr(3'd0, 8'h07);
    pulse_cnt(1);
    rd16(3'd1, w); chk("R7 wrap to zero", w, 16'h0000);
    rd(3'd0, b);   chk("R7 ovf flag cap", b, 8'h87);

    // R10 software set and clear
    wr(3'd0, 8'h00);
    repeat (2) @(negedge clk);
    chk("R10 irq low", irq, 1'b0);
    wr(3'd0, 8'h40);
    repeat (2) @(negedge clk);
    chk("R10 sw ext set", irq, 1'b1);
    wr(3'd0, 8'h80);
    rd(3'd0, b);   chk("R10 sw ovf set", b, 8'h80);
    wr(3'd0, 8'h00);
    repeat (2) @(negedge clk);
    chk("R10 sw clear", irq, 1'b0);

    // R8 baud receive
    fast_tick_sel = 1'b1;
    wr16(3'd3, 16'hFFF0);
    wr16(3'd1, 16'hFFF0);
    rxc = 0; txc = 0;
    wr(3'd0, 8'h11);
    for (int j = 1; j <= 200; j++) begin
      @(negedge clk);
      if (rx_baud_tick) rxc++;
      if (tx_baud_tick) txc++;
    end
    rd(3'd0, b);
    chk("R8 rx pulses", rxc, 6);
    chk("R8 tx silent", txc, 0);
    chk("R8 no ovf flag", b, 8'h11);
    wr(3'd0, 8'h00);
    // R8 baud transmit
    fast_tick_sel = 1'b0;
    wr16(3'd1, 16'hFFF0);
    rxc = 0; txc = 0;
    wr(3'd0, 8'h21);
    for (int j = 1; j <= 100; j++) begin
      @(negedge clk);
      if (rx_baud_tick) rxc++;
      if (tx_baud_tick) txc++;
    end
    wr(3'd0, 8'h00);
    chk("R8 tx pulses", txc, 3);
    chk("R8 rx silent", rxc, 0);

    // R9 baud mode ignores trigger
    wr(3'd0, 8'h1C);
    fall_trig();
    rd16(3'd3, w); chk("R9 no capture", w, 16'hFFF0);
    rd(3'd0, b);   chk("R9 no ext flag", b, 8'h1C);
    wr(3'd0, 8'h00);

    // R11 capture and wrap together
    wr16(3'd3, 16'h0000);
    wr16(3'd1, 16'hFFFF);
    wr(3'd0, 8'h0F);
    cnt_pin = 1'b0; trig_pin = 1'b0;
    repeat (5) @(negedge clk);
    cnt_pin = 1'b1; trig_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd16(3'd3, w); chk("R11 capture value", w, 16'hFFFF);
    rd16(3'd1, w); chk("R11 counter", w, 16'h0000);
    rd(3'd0, b);   chk("R11 both flags", b, 8'hCF);

    done = 1;
    summary();
    $finish;
  end
endmodule